// File: doc/BRIEF.md
# Dual-Bus Data Memory Access Unit

This block is a word-organised data memory with two read paths. The X port serves every instruction and does byte and word reads and writes over a 16-bit byte address. The Y port is read-only and word-only, and it feeds operand prefetch for multiply-accumulate operations. Each 16-bit word is held as two byte lanes. The two lanes share one word index, but each lane has its own write enable.

Every access is checked against two fixed limits: the boundary between X space and Y space, and the size of the implemented memory. A fetch that is not valid returns zero. Both limits are set by parameters at elaboration time. X space covers byte addresses below `Y_BASE`. Y space runs from `Y_BASE` up to `MEM_BYTES`.

A word access at an odd address raises a trap flag. If that access is a store, the store is suppressed. If it is a load, the load still returns the word at the even address below it. Both ports give their read data, and the trap flag, one cycle after the request.

Top module: `dmem_xy_unit`

## Requirements
- R1: A word write on the X port (`x_req_i`=1, `x_we_i`=1, `x_byte_i`=0, even address below `MEM_BYTES`) stores `x_wdata_i`. A plain X read (`x_mac_i`=0) of any implemented even address, in X space or in Y space, returns that word on `x_rdata_o` in the cycle after the request.
- R2: An X byte read (`x_byte_i`=1) returns the byte selected by address bit 0 on `x_rdata_o[7:0]`: bit 0 = 0 selects bits 7:0 of the word, and bit 0 = 1 selects bits 15:8. `x_rdata_o[15:8]` reads as zero.
- R3: An X byte write takes its data from `x_wdata_i[7:0]` and updates only the lane picked by address bit 0. The other byte of the word keeps its value.
- R4: `trap_o` is 1 in the cycle after a word request with address bit 0 set, on either port. It is 0 after every other cycle, including byte accesses at odd addresses.
- R5: A misaligned X word write leaves the memory unchanged.
- R6: A misaligned X word read completes and returns the word at the address with bit 0 cleared.
- R7: An X read with `x_mac_i`=1 at an address at or above `Y_BASE` returns zero. `x_mac_i` has no effect on writes, which may store into Y space.
- R8: The Y port returns the stored word for addresses in `[Y_BASE, MEM_BYTES)` and returns zero for addresses below `Y_BASE`.
- R9: Reads at addresses at or above `MEM_BYTES` return zero on both ports. Writes there are dropped, they do not alias onto implemented words, and they do not trap unless they are misaligned.
- R10: A Y request at an odd address traps and returns the word at the even address below it.
- R11: When an X write and a Y read hit the same word in the same cycle, the Y port returns the contents from before the write.
- R12: While reset is held, `x_rdata_o`, `y_rdata_o` and `trap_o` are zero.
- R13: After a cycle with no read on a port (no request, or an X write), that port's read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| x_req_i | input | 1 | X port request |
| x_we_i | input | 1 | X port write (1) or read (0) |
| x_byte_i | input | 1 | X access size: byte (1) or word (0) |
| x_mac_i | input | 1 | X read is a multiply-accumulate operand fetch |
| x_addr_i | input | ADDR_W | X byte address |
| x_wdata_i | input | 16 | X write data; a byte write uses bits 7:0 |
| x_rdata_o | output | 16 | X read data, one cycle after the request |
| y_req_i | input | 1 | Y port read request |
| y_addr_i | input | ADDR_W | Y byte address |
| y_rdata_o | output | 16 | Y read data, one cycle after the request |
| trap_o | output | 1 | Address-error trap for a misaligned word access |

## Verification
Two events can land in the same cycle. First, an X store and a Y prefetch of the same word: the bench issues both together and expects the Y port to return the old word, then reads again and expects the new one. Second, a misaligned access on each port in one cycle: the bench expects `trap_o` to be high for that cycle while each port still returns its own aligned data. A reference model in the bench predicts, for every cycle, both ports' read data and the trap level. It takes its read predictions before it applies that cycle's store.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    SPACE_ANY = 2'd0,
    SPACE_X   = 2'd1,
    SPACE_Y   = 2'd2
  } space_e;
endpackage

// File: rtl/dmem_addr_check.sv
module dmem_addr_check
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MEM_BYTES = 256,
  parameter int unsigned Y_BASE    = 128,
  parameter int unsigned IDX_W     = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  space_e            space_i,
  output logic              reach_o,
  output logic              misalign_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam bit FULL = MEM_BYTES >= (32'd1 << ADDR_W);

  logic phys, in_y, space_ok;

  generate
    if (FULL) begin : g_full
      assign phys = 1'b1;
    end else begin : g_part
      assign phys = 32'(addr_i) < MEM_BYTES;
    end
  endgenerate

  assign in_y = 32'(addr_i) >= Y_BASE;

  always_comb begin
    unique case (space_i)
      SPACE_X: space_ok = !in_y;
      SPACE_Y: space_ok = in_y;
      default: space_ok = 1'b1;
    endcase
  end

  assign reach_o    = phys & space_ok;
  assign misalign_o = word_i & addr_i[0];
  assign idx_o      = addr_i[IDX_W:1];
endmodule

// File: rtl/dmem_lane_array.sv
module dmem_lane_array
  import dmem_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned WORDS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANES-1:0]  we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ra_en_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic              rb_en_i,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic [DATA_W-1:0] rb_data_o
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] mem [WORDS];
      logic [7:0] ra_q, rb_q;

      always_ff @(posedge clk_i) begin
        if (we_i[g]) mem[widx_i] <= wdata_i[8*g +: 8];
      end

      // both read registers sample before the same-edge write lands
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ra_q <= '0;
          rb_q <= '0;
        end else begin
          if (ra_en_i) ra_q <= mem[ra_idx_i];
          if (rb_en_i) rb_q <= mem[rb_idx_i];
        end
      end

      assign ra_data_o[8*g +: 8] = ra_q;
      assign rb_data_o[8*g +: 8] = rb_q;
    end
  endgenerate
endmodule

// File: rtl/dmem_read_steer.sv
module dmem_read_steer
  import dmem_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  input  logic              ok_i,
  input  logic              byte_i,
  input  logic              hi_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    if (!ok_i)       data_o = '0;
    else if (byte_i) data_o = {8'h00, hi_i ? word_i[15:8] : word_i[7:0]};
    else             data_o = word_i;
  end
endmodule

// File: rtl/dmem_xy_unit.sv
module dmem_xy_unit
  import dmem_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned MEM_BYTES = 256,
  parameter int unsigned Y_BASE    = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              x_req_i,
  input  logic              x_we_i,
  input  logic              x_byte_i,
  input  logic              x_mac_i,
  input  logic [ADDR_W-1:0] x_addr_i,
  input  logic [15:0]       x_wdata_i,
  output logic [15:0]       x_rdata_o,
  input  logic              y_req_i,
  input  logic [ADDR_W-1:0] y_addr_i,
  output logic [15:0]       y_rdata_o,
  output logic              trap_o
);
  localparam int unsigned WORDS = MEM_BYTES / 2;
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic             x_rd, x_wr, x_reach, x_mis, y_reach, y_mis;
  logic [IDX_W-1:0] x_idx, y_idx;
  space_e           x_space;
  logic [LANES-1:0] lane_we;
  logic [15:0]      wdata, x_word, y_word;
  logic             x_ok_q, x_byte_q, x_hi_q, y_ok_q, trap_q;

  assign x_rd    = x_req_i & ~x_we_i;
  assign x_wr    = x_req_i & x_we_i;
  // operand-fetch restriction only applies to reads
  assign x_space = (x_mac_i && !x_we_i) ? SPACE_X : SPACE_ANY;

  dmem_addr_check #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .Y_BASE(Y_BASE), .IDX_W(IDX_W)
  ) u_x_chk (
    .addr_i(x_addr_i), .word_i(~x_byte_i), .space_i(x_space),
    .reach_o(x_reach), .misalign_o(x_mis), .idx_o(x_idx)
  );

  dmem_addr_check #(
    .ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .Y_BASE(Y_BASE), .IDX_W(IDX_W)
  ) u_y_chk (
    .addr_i(y_addr_i), .word_i(1'b1), .space_i(SPACE_Y),
    .reach_o(y_reach), .misalign_o(y_mis), .idx_o(y_idx)
  );

  always_comb begin
    lane_we = '0;
    if (x_wr && x_reach && !x_mis) begin
      if (x_byte_i) lane_we = x_addr_i[0] ? 2'b10 : 2'b01;
      else          lane_we = 2'b11;
    end
  end

  assign wdata = x_byte_i ? {2{x_wdata_i[7:0]}} : x_wdata_i;

  dmem_lane_array #(.IDX_W(IDX_W), .WORDS(WORDS)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(lane_we), .widx_i(x_idx), .wdata_i(wdata),
    .ra_en_i(x_rd & x_reach), .ra_idx_i(x_idx),
    .rb_en_i(y_req_i & y_reach), .rb_idx_i(y_idx),
    .ra_data_o(x_word), .rb_data_o(y_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_ok_q   <= 1'b0;
      x_byte_q <= 1'b0;
      x_hi_q   <= 1'b0;
      y_ok_q   <= 1'b0;
      trap_q   <= 1'b0;
    end else begin
      x_ok_q   <= x_rd & x_reach;
      x_byte_q <= x_byte_i;
      x_hi_q   <= x_addr_i[0];
      y_ok_q   <= y_req_i & y_reach;
      trap_q   <= (x_req_i & x_mis) | (y_req_i & y_mis);
    end
  end

  dmem_read_steer u_x_steer (
    .word_i(x_word), .ok_i(x_ok_q), .byte_i(x_byte_q), .hi_i(x_hi_q), .data_o(x_rdata_o)
  );

  dmem_read_steer u_y_steer (
    .word_i(y_word), .ok_i(y_ok_q), .byte_i(1'b0), .hi_i(1'b0), .data_o(y_rdata_o)
  );

  assign trap_o = trap_q;

  a_r9_x_beyond_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_req_i && !x_we_i && 32'(x_addr_i) >= MEM_BYTES |=> x_rdata_o == '0);
  a_r7_mac_y_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_req_i && !x_we_i && x_mac_i && 32'(x_addr_i) >= Y_BASE |=> x_rdata_o == '0);
  a_r8_y_in_x_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_req_i && 32'(y_addr_i) < Y_BASE |=> y_rdata_o == '0);
  a_r2_byte_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_req_i && !x_we_i && x_byte_i |=> x_rdata_o[15:8] == 8'h00);
  a_r4_trap_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_req_i && !x_byte_i && x_addr_i[0]) || (y_req_i && y_addr_i[0]) |=> trap_o);
  a_r4_trap_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(x_req_i && !x_byte_i && x_addr_i[0]) && !(y_req_i && y_addr_i[0]) |=> !trap_o);
  a_r13_x_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(x_req_i && !x_we_i) |=> x_rdata_o == '0);
  a_r13_y_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_req_i |=> y_rdata_o == '0);
  a_r5_no_write_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_req_i && x_we_i && !x_byte_i && x_addr_i[0] |-> lane_we == '0);
endmodule

// File: tb/tb_dmem_xy_unit.sv
module tb_dmem_xy_unit;
  localparam int unsigned MB = 256;
  localparam int unsigned YB = 128;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        x_req_i = 0, x_we_i = 0, x_byte_i = 0, x_mac_i = 0, y_req_i = 0;
  logic [15:0] x_addr_i = '0, x_wdata_i = '0, y_addr_i = '0;
  logic [15:0] x_rdata_o, y_rdata_o;
  logic        trap_o;

  always #5 clk_i = ~clk_i;

  dmem_xy_unit #(.ADDR_W(16), .MEM_BYTES(MB), .Y_BASE(YB)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .x_req_i(x_req_i), .x_we_i(x_we_i), .x_byte_i(x_byte_i), .x_mac_i(x_mac_i),
    .x_addr_i(x_addr_i), .x_wdata_i(x_wdata_i), .x_rdata_o(x_rdata_o),
    .y_req_i(y_req_i), .y_addr_i(y_addr_i), .y_rdata_o(y_rdata_o), .trap_o(trap_o)
  );

  logic [15:0] model [MB/2];
  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_x(input logic [15:0] a, input logic b, input logic m);
    logic [15:0] w;
    if (32'(a) >= MB) return 16'h0;
    if (m && 32'(a) >= YB) return 16'h0;
    w = model[a[7:1]];
    if (b) return {8'h00, a[0] ? w[15:8] : w[7:0]};
    return w;
  endfunction

  function automatic logic [15:0] exp_y(input logic [15:0] a);
    if (32'(a) >= MB || 32'(a) < YB) return 16'h0;
    return model[a[7:1]];
  endfunction

  task automatic run(input string tag, input logic xr, input logic xw, input logic xb,
                     input logic xm, input logic [15:0] xa, input logic [15:0] xd,
                     input logic yr, input logic [15:0] ya);
    logic [15:0] ex, ey;
    logic        et;
    ex = (xr && !xw) ? exp_x(xa, xb, xm) : 16'h0;
    ey = yr ? exp_y(ya) : 16'h0;
    et = (xr && !xb && xa[0]) || (yr && ya[0]);
    x_req_i = xr; x_we_i = xw; x_byte_i = xb; x_mac_i = xm;
    x_addr_i = xa; x_wdata_i = xd; y_req_i = yr; y_addr_i = ya;
    @(negedge clk_i);
    if (xr && xw && 32'(xa) < MB && !(!xb && xa[0])) begin
      if (!xb) model[xa[7:1]] = xd;
      else if (xa[0]) model[xa[7:1]][15:8] = xd[7:0];
      else model[xa[7:1]][7:0] = xd[7:0];
    end
    chk(tag, "x_rdata", x_rdata_o, ex);
    chk(tag, "y_rdata", y_rdata_o, ey);
    chk(tag, "trap", {15'h0, trap_o}, {15'h0, et});
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < int'(MB / 2); i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    chk("R12", "x_rdata", x_rdata_o, 16'h0);
    chk("R12", "y_rdata", y_rdata_o, 16'h0);
    chk("R12", "trap", {15'h0, trap_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < int'(MB / 2); i++)
      run("R1", 1, 1, 0, 0, 16'(2 * i), 16'(i * 16'h0137) ^ 16'hA5C3, 0, 16'h0);
    for (int i = 0; i < int'(MB / 2); i++)
      run("R1", 1, 0, 0, 0, 16'(2 * i), 16'h0, 0, 16'h0);
    for (int i = 0; i < int'(MB / 2); i++)
      run("R8", 0, 0, 0, 0, 16'h0, 16'h0, 1, 16'(2 * i));
    for (int i = 0; i < int'(MB / 2); i++)
      run("R7", 1, 0, 0, 1, 16'(2 * i), 16'h0, 0, 16'h0);
    for (int i = 0; i < int'(MB); i++)
      run("R2", 1, 0, 1, 0, 16'(i), 16'h0, 0, 16'h0);

    for (int i = 0; i < int'(MB); i += 5)
      run("R3", 1, 1, 1, 0, 16'(i), {8'hEE, 8'(i) ^ 8'h3C}, 0, 16'h0);
    for (int i = 0; i < int'(MB / 2); i++)
      run("R3", 1, 0, 0, 0, 16'(2 * i), 16'h0, 0, 16'h0);

    run("R7", 1, 1, 0, 1, 16'h00A0, 16'h7E81, 0, 16'h0);
    run("R7", 1, 0, 0, 0, 16'h00A0, 16'h0, 0, 16'h0);
    run("R7", 1, 0, 0, 1, 16'h00A0, 16'h0, 0, 16'h0);
    run("R7", 1, 0, 0, 1, 16'h007E, 16'h0, 0, 16'h0);

    run("R9", 1, 0, 0, 0, 16'h0102, 16'h0, 1, 16'h8000);
    run("R9", 1, 0, 1, 0, 16'hFFFF, 16'h0, 1, 16'h0100);
    run("R9", 1, 1, 0, 0, 16'h0102, 16'hBAD1, 0, 16'h0);
    run("R9", 1, 1, 1, 0, 16'h0103, 16'hBAD2, 0, 16'h0);
    run("R9", 1, 0, 0, 0, 16'h0002, 16'h0, 0, 16'h0);

    run("R5", 1, 1, 0, 0, 16'h0011, 16'hDEAD, 0, 16'h0);
    run("R5", 1, 0, 0, 0, 16'h0010, 16'h0, 0, 16'h0);
    run("R5", 1, 0, 0, 0, 16'h0012, 16'h0, 0, 16'h0);
    run("R6", 1, 0, 0, 0, 16'h0021, 16'h0, 0, 16'h0);
    run("R6", 1, 0, 1, 0, 16'h0021, 16'h0, 0, 16'h0);
    run("R10", 0, 0, 0, 0, 16'h0, 16'h0, 1, 16'h0081);
    run("R10", 0, 0, 0, 0, 16'h0, 16'h0, 1, 16'h00FF);
    run("R4", 1, 0, 0, 0, 16'h0031, 16'h0, 1, 16'h0091);

    run("R11", 1, 1, 0, 0, 16'h0090, 16'h1234, 1, 16'h0090);
    run("R11", 0, 0, 0, 0, 16'h0, 16'h0, 1, 16'h0090);
    run("R11", 1, 1, 1, 0, 16'h0091, 16'h00AB, 1, 16'h0090);
    run("R11", 1, 0, 0, 0, 16'h0090, 16'h0, 1, 16'h0090);

    run("R13", 0, 0, 0, 0, 16'h0090, 16'h0, 0, 16'h0090);
    run("R13", 1, 1, 0, 0, 16'h0040, 16'h5555, 0, 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule